// File: doc/BRIEF.md
# ALU with Operation Decoder

This block is the arithmetic and logic stage of a small 16-bit processor datapath. It combines a two-operand ALU with a compact decoder. The decoder chooses the operation from two sources. The first is a 2-bit operation code from the processor controller, which can force an add, a subtract or an AND. The second is the 3-bit function field of the current instruction, which is used when the controller defers to the instruction.

The ALU performs add, subtract, AND, XOR, logical left shift and logical right shift. Next to the 16-bit result it produces a zero flag and a negative flag. A branch-select input picks one of the two flags as the branch-taken indication. A less-than branch uses the negative flag, and an equality branch uses the zero flag. A function code with no defined operation gives a zero result and raises an illegal-function flag.

All outputs are registered and appear one clock after the inputs are presented.

Top module: `alu_unit`

## Requirements
- R1: With opCode = 2'b00 the result is (opA + opB) mod 2^16, whatever the function field.
- R2: With opCode = 2'b01 the result is (opA - opB) mod 2^16, whatever the function field.
- R3: With opCode = 2'b10 the result is opA & opB, whatever the function field.
- R4: With opCode = 2'b11 the function field selects the operation: 3'b000 add, 3'b001 subtract, 3'b010 AND, 3'b011 XOR.
- R5: With opCode = 2'b11, function 3'b100 gives opA shifted left logically, and 3'b101 gives opA shifted right logically (zero fill). In both cases the shift distance is opB[3:0].
- R6: With opCode = 2'b11 and function 3'b110 or 3'b111 the result is 0 and illegalFunc is 1. In every other case illegalFunc is 0.
- R7: negFlag is 1 exactly when bit 15 of the result is 1.
- R8: zeroFlag is 1 exactly when the result is 16'h0000.
- R9: branchHit equals negFlag when branchSel was 0, and equals zeroFlag when branchSel was 1.
- R10: Every output is registered and changes on the first rising clock edge after its inputs. While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opA | input | 16 | First operand; the value that is shifted |
| opB | input | 16 | Second operand; bits [3:0] give the shift distance |
| opCode | input | 2 | Controller operation code: forced add, forced subtract, forced AND, or decode the function field |
| funcField | input | 3 | Function field taken from the instruction |
| branchSel | input | 1 | Branch flag select: 0 picks negative, 1 picks zero |
| result | output | 16 | Registered ALU result |
| zeroFlag | output | 1 | Result equals zero |
| negFlag | output | 1 | Result bit 15 |
| branchHit | output | 1 | The selected branch flag |
| illegalFunc | output | 1 | An undefined function code was decoded |

## Verification
The assertions check the following on every cycle:
- the flags match the registered result;
- branchHit follows the select value captured one cycle earlier;
- an illegal decode always leaves a zero result;
- a forced add produces the registered sum.

The bench scenarios are needed for the rest:
- the arithmetic of every operation under random operands;
- the full decode of every function code under the decode code, and its independence under the forcing codes;
- shift distances of 0 and 15;
- wrap-around at the ends of the range;
- the one-cycle output latency.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int FUNC_W = 3;
  localparam int OPC_W  = 2;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_XOR  = 3'd3,
    OP_SHL  = 3'd4,
    OP_SHR  = 3'd5,
    OP_ZERO = 3'd6
  } aluOp_e;

  typedef struct packed {
    aluOp_e op;
    logic   useFunc;
    logic   illegal;
  } aluCtrl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [OPC_W-1:0]  opCode,
  input  logic [FUNC_W-1:0] funcField,
  output aluCtrl_t          ctrl
);

  aluOp_e funcOp;
  logic   funcBad;

  // Decode of the instruction function field
  always_comb begin
    funcBad = 1'b0;
    case (funcField)
      3'd0:    funcOp = OP_ADD;
      3'd1:    funcOp = OP_SUB;
      3'd2:    funcOp = OP_AND;
      3'd3:    funcOp = OP_XOR;
      3'd4:    funcOp = OP_SHL;
      3'd5:    funcOp = OP_SHR;
      default: begin
        funcOp  = OP_ZERO;
        funcBad = 1'b1;
      end
    endcase
  end

  // The controller code either forces an operation or defers to the instruction
  always_comb begin
    ctrl = '{op: OP_ADD, useFunc: 1'b0, illegal: 1'b0};
    case (opCode)
      2'b00: ctrl.op = OP_ADD;
      2'b01: ctrl.op = OP_SUB;
      2'b10: ctrl.op = OP_AND;
      default: begin
        ctrl.op      = funcOp;
        ctrl.useFunc = 1'b1;
        ctrl.illegal = funcBad;
      end
    endcase
  end

  // R1..R3: forcing codes never report an illegal function
  always_comb begin
    if (opCode != 2'b11) begin
      a_r6_forced_never_illegal: assert (!ctrl.illegal && !ctrl.useFunc);
    end
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluCtrl_t         ctrl,
  input  logic             branchSel,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             negFlag,
  output logic             branchHit,
  output logic             illegalFunc
);

  localparam int SHW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [WIDTH-1:0] nextRes;
  logic [SHW-1:0]   shAmt;
  logic             nextZero;
  logic             nextNeg;
  logic             armed;

  assign shAmt = opB[SHW-1:0];

  always_comb begin
    case (ctrl.op)
      OP_ADD:  nextRes = opA + opB;
      OP_SUB:  nextRes = opA - opB;
      OP_AND:  nextRes = opA & opB;
      OP_XOR:  nextRes = opA ^ opB;
      OP_SHL:  nextRes = opA << shAmt;
      OP_SHR:  nextRes = opA >> shAmt;
      default: nextRes = '0;
    endcase
  end

  assign nextZero = (nextRes == '0);
  assign nextNeg  = nextRes[WIDTH-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result      <= '0;
      zeroFlag    <= 1'b0;
      negFlag     <= 1'b0;
      branchHit   <= 1'b0;
      illegalFunc <= 1'b0;
      armed       <= 1'b0;
    end else begin
      result      <= nextRes;
      zeroFlag    <= nextZero;
      negFlag     <= nextNeg;
      branchHit   <= branchSel ? nextZero : nextNeg;
      illegalFunc <= ctrl.illegal;
      armed       <= 1'b1;
    end
  end

  a_r7_neg_is_msb: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (negFlag == result[WIDTH-1]));

  a_r8_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (zeroFlag == (result == '0)));

  a_r9_branch_pick: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (branchHit == ($past(branchSel) ? zeroFlag : negFlag)));

  a_r6_illegal_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
    illegalFunc |-> (result == '0 && zeroFlag));

endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic [OPC_W-1:0]  opCode,
  input  logic [FUNC_W-1:0] funcField,
  input  logic              branchSel,
  output logic [WIDTH-1:0]  result,
  output logic              zeroFlag,
  output logic              negFlag,
  output logic              branchHit,
  output logic              illegalFunc
);

  aluCtrl_t ctrlBus;
  logic     topArmed;

  alu_ctrl u_ctrl (
    .opCode    (opCode),
    .funcField (funcField),
    .ctrl      (ctrlBus)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .opA         (opA),
    .opB         (opB),
    .ctrl        (ctrlBus),
    .branchSel   (branchSel),
    .result      (result),
    .zeroFlag    (zeroFlag),
    .negFlag     (negFlag),
    .branchHit   (branchHit),
    .illegalFunc (illegalFunc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) topArmed <= 1'b0;
    else        topArmed <= 1'b1;
  end

  a_r1_forced_add: assert property (@(posedge clk) disable iff (!rst_n)
    (topArmed && $past(opCode) == 2'b00) |->
      (result == WIDTH'($past(opA) + $past(opB)) && !illegalFunc));

  a_r10_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (result == '0 && !zeroFlag && !negFlag && !branchHit && !illegalFunc));

endmodule

// File: tb/alu_unit_tb_top.sv
`timescale 1ns/1ps
module alu_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic [1:0]  opCode = '0;
  logic [2:0]  funcField = '0;
  logic        branchSel = 1'b0;
  logic [15:0] result;
  logic        zeroFlag, negFlag, branchHit, illegalFunc;

  int  nRun = 0;
  int  nFail = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  alu_unit dut_i (
    .clk(clk), .rst_n(rst_n), .opA(opA), .opB(opB), .opCode(opCode),
    .funcField(funcField), .branchSel(branchSel), .result(result),
    .zeroFlag(zeroFlag), .negFlag(negFlag), .branchHit(branchHit),
    .illegalFunc(illegalFunc)
  );

  function automatic logic [15:0] expRes(logic [15:0] a, logic [15:0] b,
                                         logic [1:0] oc, logic [2:0] fn);
    case (oc)
      2'b00: return a + b;
      2'b01: return a - b;
      2'b10: return a & b;
      default: case (fn)
        3'd0: return a + b;
        3'd1: return a - b;
        3'd2: return a & b;
        3'd3: return a ^ b;
        3'd4: return a << b[3:0];
        3'd5: return a >> b[3:0];
        default: return 16'h0000;
      endcase
    endcase
  endfunction

  function automatic string reqTag(logic [1:0] oc, logic [2:0] fn);
    if (oc == 2'b00) return "R1";
    if (oc == 2'b01) return "R2";
    if (oc == 2'b10) return "R3";
    if (fn < 3'd4)   return "R4";
    if (fn < 3'd6)   return "R5";
    return "R6";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    nRun++;
    if (act !== expv) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // Drive one vector at a falling edge and check outputs one edge later (R10 latency)
  task automatic runVec(logic [15:0] a, logic [15:0] b, logic [1:0] oc,
                        logic [2:0] fn, logic bs);
    logic [15:0] er;
    logic ez, en;
    string t;
    er = expRes(a, b, oc, fn);
    ez = (er == 16'h0000);
    en = er[15];
    t = reqTag(oc, fn);
    opA = a; opB = b; opCode = oc; funcField = fn; branchSel = bs;
    @(posedge clk);
    @(negedge clk);
    chk(t, {16'h0, result}, {16'h0, er});
    chk("R6 illegal flag", {31'h0, illegalFunc},
        {31'h0, (oc == 2'b11 && fn > 3'd5)});
    chk("R7 neg", {31'h0, negFlag}, {31'h0, en});
    chk("R8 zero", {31'h0, zeroFlag}, {31'h0, ez});
    chk("R9 branch", {31'h0, branchHit}, {31'h0, (bs ? ez : en)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(552);
    repeat (3) @(negedge clk);
    // R10: reset clears outputs
    chk("R10 reset", {11'h0, result, zeroFlag, negFlag, branchHit, illegalFunc, 1'b0}, 32'h0);
    opA = 16'h1234; opB = 16'h1111; opCode = 2'b00;
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corner cases
    runVec(16'hFFFF, 16'h0001, 2'b00, 3'd1, 1'b1);  // R1 wrap to zero, func ignored
    runVec(16'h0000, 16'h0001, 2'b01, 3'd3, 1'b0);  // R2 borrow -> negative
    runVec(16'h1234, 16'h1234, 2'b01, 3'd0, 1'b1);  // R2 zero result
    runVec(16'hF0F0, 16'h0F0F, 2'b10, 3'd4, 1'b1);  // R3 AND = 0
    runVec(16'hAAAA, 16'h5555, 2'b11, 3'd3, 1'b0);  // R4 XOR
    runVec(16'h8001, 16'h0000, 2'b11, 3'd4, 1'b0);  // R5 shift by 0
    runVec(16'h0001, 16'h000F, 2'b11, 3'd4, 1'b0);  // R5 shift left by 15
    runVec(16'h8000, 16'hFFFF, 2'b11, 3'd5, 1'b0);  // R5 shift right by 15, zero fill
    runVec(16'hFFFF, 16'hFFFF, 2'b11, 3'd6, 1'b1);  // R6 illegal
    runVec(16'h7FFF, 16'h0001, 2'b11, 3'd7, 1'b0);  // R6 illegal
    runVec(16'h7FFF, 16'h0001, 2'b11, 3'd0, 1'b0);  // R4 add into sign bit

    // R10: output holds until the clock edge
    opA = 16'h0003; opB = 16'h0004; opCode = 2'b00; funcField = 3'd0;
    #2;
    chk("R10 registered", {16'h0, result}, 32'h0000_8000);
    @(posedge clk); @(negedge clk);
    chk("R10 after edge", {16'h0, result}, 32'h0000_0007);

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a, b;
      logic [1:0]  oc;
      logic [2:0]  fn;
      a  = 16'($urandom);
      b  = 16'($urandom);
      if ((i % 7) == 0) b = a;
      oc = 2'($urandom);
      fn = 3'($urandom);
      runVec(a, b, oc, fn, 1'($urandom));
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule